// File: doc/BRIEF.md
# Hardware LIFO Stack Controller

This block keeps a last-in, first-out stack in a small register array and manages its stack pointer. A client raises a push request with a data word to store it, or a pop request to get back the most recent word still held. The word comes out one cycle after the pop request, marked by a one-cycle valid pulse. The stack pointer is visible on an output so that a surrounding datapath can follow the stack position. Occupancy flags for full and empty guard against overflow and underflow. A request that cannot be honoured is dropped and reported by a one-cycle error pulse.

Two parameters fix the stack convention at build time. One sets the growth direction: toward larger or toward smaller slot numbers. The other sets what the pointer marks. In last-full form it marks the slot holding the top word, so a push steps the pointer before writing and a pop reads before stepping back. In next-empty form it marks the slot the next push will use, so a push writes before stepping and a pop steps back before reading. All four combinations are built from one source. Requesting push and pop in the same cycle is treated as a client error.

Top module: `hw_stack`

## Requirements
- R1: After reset, empty_o is 1 and full_o, err_o and pop_valid_o are 0. sp_o holds the empty value E of its convention, taken modulo 2^SP_W: E = 0 for upward next-empty, E = -1 (all ones) for upward last-full, E = DEPTH-1 for downward next-empty, and E = DEPTH for downward last-full.
- R2: Words come back in last-in, first-out order. Each accepted pop returns the most recently pushed word that has not yet been popped, and this holds across any interleaving of pushes, pops and rejected requests.
- R3: pop_valid_o is 1 for exactly the one cycle after the clock edge that accepts a pop, and pop_data_o carries the popped word in that cycle. pop_valid_o is 0 in every other cycle.
- R4: With N words held, sp_o equals E + s*N modulo 2^SP_W. Here s is +1 when GROW_DOWN is 0 and -1 when GROW_DOWN is 1. An accepted push therefore moves sp_o one step in the growth direction, and an accepted pop moves it one step back.
- R5: full_o is 1 exactly when DEPTH words are held. empty_o is 1 exactly when no word is held.
- R6: A push requested while full_o is 1 is ignored. sp_o, the flags and the stored words are left unchanged, and err_o pulses.
- R7: A pop requested while empty_o is 1 is ignored. No pop_valid_o pulse follows, sp_o stays unchanged, and err_o pulses.
- R8: A push and a pop requested in the same cycle are both ignored. No word is stored or returned, sp_o stays unchanged, and err_o pulses.
- R9: err_o is 1 for exactly the one cycle after the clock edge that sees a rejected request (as in R6, R7 or R8), and 0 in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released through a synchroniser |
| push_i | input | 1 | Push request for this cycle |
| push_data_i | input | DW | Word to store on a push |
| pop_i | input | 1 | Pop request for this cycle |
| pop_data_o | output | DW | Popped word, meaningful while pop_valid_o is 1 |
| pop_valid_o | output | 1 | One-cycle pulse after an accepted pop |
| sp_o | output | SP_W | Current stack pointer |
| full_o | output | 1 | DEPTH words held |
| empty_o | output | 1 | No word held |
| err_o | output | 1 | One-cycle pulse after a rejected request |

## Verification
The bench builds four copies of the block with DEPTH = 4 and DW = 8, one for each combination of GROW_DOWN and LAST_FULL. All four copies are driven by the same request stream. The small depth makes the full boundary, pushes into a full stack and pointer wrap reachable within a few cycles. These include the all-ones empty pointer of the upward last-full form and the out-of-range value DEPTH of the downward last-full form. Because every copy must return the same words from one shared scoreboard, any difference between the four update-and-access orderings shows up as a data mismatch. The expected pointer is computed separately for each convention.

// File: rtl/hw_stack_pkg.sv
package hw_stack_pkg;

  // Request decode: bit 0 is push, bit 1 is pop.
  typedef enum logic [1:0] {
    REQ_NONE  = 2'd0,
    REQ_PUSH  = 2'd1,
    REQ_POP   = 2'd2,
    REQ_CLASH = 2'd3
  } req_e;

  // Pointer value of an empty stack for a given convention.
  function automatic int sp_at_empty(int unsigned depth, bit grow_down, bit last_full);
    int v;
    if (!grow_down) v = last_full ? -1 : 0;
    else            v = last_full ? int'(depth) : int'(depth) - 1;
    return v;
  endfunction

endpackage

// File: rtl/hw_stack_rst_sync.sv
module hw_stack_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/hw_stack_mem.sv
module hw_stack_mem #(
  parameter int unsigned DW    = 8,
  parameter int unsigned DEPTH = 8,
  parameter int unsigned AW    = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data
);

  logic [DW-1:0] slot_q [DEPTH];

  // Storage array: no reset, written only on an accepted push.
  always_ff @(posedge clk) begin
    if (wr_en) begin
      slot_q[wr_addr] <= wr_data;
    end
  end

  // Registered read port, loaded only on an accepted pop.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data <= '0;
    end else if (rd_en) begin
      rd_data <= slot_q[rd_addr];
    end
  end

endmodule

// File: rtl/hw_stack_ctrl.sv
module hw_stack_ctrl
  import hw_stack_pkg::*;
#(
  parameter int unsigned DEPTH     = 8,
  parameter int unsigned PW        = 4,
  parameter int unsigned AW        = 3,
  parameter bit          GROW_DOWN = 1'b0,
  parameter bit          LAST_FULL = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_i,
  input  logic          pop_i,
  output logic          wr_en_o,
  output logic [AW-1:0] wr_addr_o,
  output logic          rd_en_o,
  output logic [AW-1:0] rd_addr_o,
  output logic [PW-1:0] sp_o,
  output logic          full_o,
  output logic          empty_o,
  output logic          err_o,
  output logic          pop_valid_o
);

  localparam int unsigned   CW      = $clog2(DEPTH + 1);
  localparam logic [PW-1:0] SP_RST  = PW'(sp_at_empty(DEPTH, GROW_DOWN, LAST_FULL));
  localparam logic [CW-1:0] CNT_TOP = CW'(DEPTH);

  logic [PW-1:0] sp_q, sp_d, sp_fwd, sp_bwd;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          err_q, pv_q;
  logic          push_ok, pop_ok, bad, state_en;
  req_e          req;

  // One step in the growth direction (fwd) and one step back (bwd).
  if (GROW_DOWN) begin : g_down
    assign sp_fwd = sp_q - PW'(1);
    assign sp_bwd = sp_q + PW'(1);
  end else begin : g_up
    assign sp_fwd = sp_q + PW'(1);
    assign sp_bwd = sp_q - PW'(1);
  end

  // Access ordering: last-full writes after stepping and reads before;
  // next-empty writes before stepping and reads after stepping back.
  if (LAST_FULL) begin : g_last_full
    assign wr_addr_o = sp_fwd[AW-1:0];
    assign rd_addr_o = sp_q[AW-1:0];
  end else begin : g_next_empty
    assign wr_addr_o = sp_q[AW-1:0];
    assign rd_addr_o = sp_bwd[AW-1:0];
  end

  assign full_o  = (cnt_q == CNT_TOP);
  assign empty_o = (cnt_q == '0);

  // Next-state logic.
  always_comb begin
    req     = req_e'({pop_i, push_i});
    push_ok = 1'b0;
    pop_ok  = 1'b0;
    bad     = 1'b0;
    unique case (req)
      REQ_NONE:  ;
      REQ_PUSH:  if (full_o)  bad = 1'b1; else push_ok = 1'b1;
      REQ_POP:   if (empty_o) bad = 1'b1; else pop_ok  = 1'b1;
      REQ_CLASH: bad = 1'b1;
    endcase

    sp_d  = sp_q;
    cnt_d = cnt_q;
    if (push_ok) begin
      sp_d  = sp_fwd;
      cnt_d = cnt_q + CW'(1);
    end else if (pop_ok) begin
      sp_d  = sp_bwd;
      cnt_d = cnt_q - CW'(1);
    end
    state_en = push_ok | pop_ok;
  end

  // State registers.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sp_q  <= SP_RST;
      cnt_q <= '0;
      err_q <= 1'b0;
      pv_q  <= 1'b0;
    end else begin
      if (state_en) begin
        sp_q  <= sp_d;
        cnt_q <= cnt_d;
      end
      err_q <= bad;
      pv_q  <= pop_ok;
    end
  end

  assign wr_en_o     = push_ok;
  assign rd_en_o     = pop_ok;
  assign sp_o        = sp_q;
  assign err_o       = err_q;
  assign pop_valid_o = pv_q;

endmodule

// File: rtl/hw_stack.sv
module hw_stack #(
  parameter int unsigned DW        = 8,
  parameter int unsigned DEPTH     = 8,
  parameter bit          GROW_DOWN = 1'b0,
  parameter bit          LAST_FULL = 1'b1,
  parameter int unsigned SP_W      = $clog2(DEPTH) + 1,
  parameter int unsigned AW        = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            push_i,
  input  logic [DW-1:0]   push_data_i,
  input  logic            pop_i,
  output logic [DW-1:0]   pop_data_o,
  output logic            pop_valid_o,
  output logic [SP_W-1:0] sp_o,
  output logic            full_o,
  output logic            empty_o,
  output logic            err_o
);

  logic          rst_q_n;
  logic          wr_en, rd_en;
  logic [AW-1:0] wr_addr, rd_addr;

  hw_stack_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_q_n)
  );

  hw_stack_ctrl #(
    .DEPTH     (DEPTH),
    .PW        (SP_W),
    .AW        (AW),
    .GROW_DOWN (GROW_DOWN),
    .LAST_FULL (LAST_FULL)
  ) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_q_n),
    .push_i      (push_i),
    .pop_i       (pop_i),
    .wr_en_o     (wr_en),
    .wr_addr_o   (wr_addr),
    .rd_en_o     (rd_en),
    .rd_addr_o   (rd_addr),
    .sp_o        (sp_o),
    .full_o      (full_o),
    .empty_o     (empty_o),
    .err_o       (err_o),
    .pop_valid_o (pop_valid_o)
  );

  hw_stack_mem #(
    .DW    (DW),
    .DEPTH (DEPTH),
    .AW    (AW)
  ) u_mem (
    .clk     (clk),
    .rst_n   (rst_q_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (push_data_i),
    .rd_en   (rd_en),
    .rd_addr (rd_addr),
    .rd_data (pop_data_o)
  );

endmodule

// File: rtl/hw_stack_chk.sv
module hw_stack_chk #(
  parameter int unsigned PW        = 4,
  parameter bit          GROW_DOWN = 1'b0
) (
  input logic          clk,
  input logic          rst_n,
  input logic          push_i,
  input logic          pop_i,
  input logic [PW-1:0] sp_o,
  input logic          full_o,
  input logic          empty_o,
  input logic          err_o,
  input logic          pop_valid_o
);

  localparam logic [PW-1:0] STEP = GROW_DOWN ? {PW{1'b1}} : PW'(1);

  a_r5_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(full_o && empty_o));

  a_r8_clash_rejected: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && pop_i) |=> (err_o && !pop_valid_o && $stable(sp_o)));

  a_r6_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && !pop_i && full_o) |=> (err_o && full_o && $stable(sp_o)));

  a_r7_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_i && !push_i && empty_o) |=> (err_o && empty_o && !pop_valid_o && $stable(sp_o)));

  a_r3_pop_valid_next: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_i && !push_i && !empty_o) |=> (pop_valid_o && !err_o));

  a_r4_push_steps: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && !pop_i && !full_o) |=> (sp_o == $past(sp_o) + STEP));

  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!push_i && !pop_i) |=> (!err_o && !pop_valid_o && $stable(sp_o)));

endmodule

bind hw_stack hw_stack_chk #(
  .PW        (SP_W),
  .GROW_DOWN (GROW_DOWN)
) u_hw_stack_chk (
  .clk         (clk),
  .rst_n       (rst_q_n),
  .push_i      (push_i),
  .pop_i       (pop_i),
  .sp_o        (sp_o),
  .full_o      (full_o),
  .empty_o     (empty_o),
  .err_o       (err_o),
  .pop_valid_o (pop_valid_o)
);

// File: tb/hw_stack_bench.sv
module hw_stack_bench;

  localparam int unsigned CLK_P = 10;
  localparam int unsigned DW    = 8;
  localparam int unsigned DEPTH = 4;
  localparam int unsigned PW    = $clog2(DEPTH) + 1;

  logic          clk;
  logic          rst_n;
  logic          push, pop;
  logic [DW-1:0] push_data;

  logic [DW-1:0] pd [4];
  logic [PW-1:0] sp [4];
  logic [3:0]    pv, err, full, empty;

  for (genvar m = 0; m < 4; m++) begin : g_mode
    hw_stack #(
      .DW        (DW),
      .DEPTH     (DEPTH),
      .GROW_DOWN (m >= 2),
      .LAST_FULL (m % 2 == 1)
    ) u_hw_stack (
      .clk         (clk),
      .rst_n       (rst_n),
      .push_i      (push),
      .push_data_i (push_data),
      .pop_i       (pop),
      .pop_data_o  (pd[m]),
      .pop_valid_o (pv[m]),
      .sp_o        (sp[m]),
      .full_o      (full[m]),
      .empty_o     (empty[m]),
      .err_o       (err[m])
    );
  end

  int unsigned   n_chk  = 0;
  int unsigned   n_fail = 0;
  bit            mon_on = 1'b0;
  logic [DW-1:0] sb_q [$];
  int            cnt     = 0;
  bit            exp_pv  = 1'b0;
  bit            exp_err = 1'b0;
  string         err_tag = "R9";

  initial begin
    clk = 1'b0;
    forever #(CLK_P/2) clk = ~clk;
  end

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // Empty pointer and step per convention, from R1 and R4 (m[1] = down, m[0] = last-full).
  function automatic logic [PW-1:0] exp_sp(input int m, input int n);
    int e;
    int s;
    if (m < 2) e = (m % 2 == 1) ? -1 : 0;
    else       e = (m % 2 == 1) ? DEPTH : DEPTH - 1;
    s = (m < 2) ? 1 : -1;
    return PW'(e + s * n);
  endfunction

  // Driver: one request per call, expectations fixed at drive time.
  task automatic req(input bit ps, input bit pp, input logic [DW-1:0] d);
    bit push_ok, pop_ok;
    @(negedge clk);
    push      = ps;
    pop       = pp;
    push_data = d;
    push_ok   = ps && !pp && (cnt < DEPTH);
    pop_ok    = pp && !ps && (cnt > 0);
    exp_pv    = pop_ok;
    exp_err   = (ps || pp) && !push_ok && !pop_ok;
    if (ps && pp)  err_tag = "R8";
    else if (ps)   err_tag = exp_err ? "R6" : "R9";
    else if (pp)   err_tag = exp_err ? "R7" : "R9";
    else           err_tag = "R9";
    if (push_ok) begin
      sb_q.push_back(d);
      cnt++;
    end
    if (pop_ok) cnt--;
  endtask

  // Monitor: samples a quarter period after each rising edge.
  initial begin
    forever begin
      @(posedge clk);
      #(CLK_P/4);
      if (mon_on) begin
        for (int m = 0; m < 4; m++) begin
          check(pv[m] == exp_pv, "R3", $sformatf("pop_valid mode %0d", m), pv[m], exp_pv);
          check(err[m] == exp_err, err_tag, $sformatf("err mode %0d", m), err[m], exp_err);
          check(sp[m] == exp_sp(m, cnt), "R4", $sformatf("sp mode %0d", m), sp[m], exp_sp(m, cnt));
          check(full[m] == (cnt == DEPTH), "R5", $sformatf("full mode %0d", m), full[m], cnt == DEPTH);
          check(empty[m] == (cnt == 0), "R5", $sformatf("empty mode %0d", m), empty[m], cnt == 0);
          if (exp_pv && sb_q.size() > 0)
            check(pd[m] == sb_q[$], "R2", $sformatf("pop data mode %0d", m), pd[m], sb_q[$]);
        end
        if (exp_pv && sb_q.size() > 0) void'(sb_q.pop_back());
      end
    end
  end

  // Watchdog.
  initial begin
    #(CLK_P * 100000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  logic [15:0] lfsr;

  initial begin
    rst_n     = 1'b0;
    push      = 1'b0;
    pop       = 1'b0;
    push_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state of every convention.
    for (int m = 0; m < 4; m++) begin
      check(sp[m] == exp_sp(m, 0), "R1", $sformatf("reset sp mode %0d", m), sp[m], exp_sp(m, 0));
      check(empty[m] == 1'b1, "R1", "reset empty", empty[m], 1);
      check(full[m] == 1'b0, "R1", "reset full", full[m], 0);
      check(err[m] == 1'b0, "R1", "reset err", err[m], 0);
      check(pv[m] == 1'b0, "R1", "reset pop_valid", pv[m], 0);
    end
    mon_on = 1'b1;

    // R7: pop while empty.
    req(1'b0, 1'b1, 8'h00);
    req(1'b0, 1'b0, 8'h00);
    // Fill to the top (R5), then overflow (R6).
    req(1'b1, 1'b0, 8'hA1);
    req(1'b1, 1'b0, 8'hB2);
    req(1'b1, 1'b0, 8'hC3);
    req(1'b1, 1'b0, 8'hD4);
    req(1'b1, 1'b0, 8'hEE);
    req(1'b1, 1'b0, 8'hEF);
    req(1'b0, 1'b0, 8'h00);
    // R8: clash while full and while partly filled.
    req(1'b1, 1'b1, 8'h55);
    req(1'b0, 1'b1, 8'h00);
    req(1'b1, 1'b1, 8'h66);
    // Drain back-to-back (R2, R3), then underflow.
    req(1'b0, 1'b1, 8'h00);
    req(1'b0, 1'b1, 8'h00);
    req(1'b0, 1'b1, 8'h00);
    req(1'b0, 1'b1, 8'h00);
    // Nested push/pop pattern.
    req(1'b1, 1'b0, 8'h10);
    req(1'b1, 1'b0, 8'h20);
    req(1'b0, 1'b1, 8'h00);
    req(1'b1, 1'b0, 8'h30);
    req(1'b1, 1'b0, 8'h40);
    req(1'b0, 1'b1, 8'h00);
    req(1'b0, 1'b1, 8'h00);
    req(1'b0, 1'b1, 8'h00);
    req(1'b0, 1'b0, 8'h00);

    // Pseudo-random mix.
    lfsr = 16'hACE1;
    for (int i = 0; i < 400; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      case (lfsr[2:0])
        3'd0, 3'd1, 3'd2: req(1'b1, 1'b0, lfsr[15:8]);
        3'd3, 3'd4, 3'd5: req(1'b0, 1'b1, lfsr[15:8]);
        3'd6:             req(1'b1, 1'b1, lfsr[15:8]);
        default:          req(1'b0, 1'b0, lfsr[15:8]);
      endcase
    end

    // Drain whatever is left.
    for (int i = 0; i < DEPTH + 1; i++) req(1'b0, 1'b1, 8'h00);
    req(1'b0, 1'b0, 8'h00);
    req(1'b0, 1'b0, 8'h00);
    @(negedge clk);
    mon_on = 1'b0;

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule